// File: doc/BRIEF.md
# Multi-lane SPI shift engine

This block moves the bytes of one SPI transaction between a transmit queue, the serial data lanes and a receive queue. It carries out one transaction of a programmed byte length on 1, 2 or 4 data lanes. A separate clock-generation block supplies `sclk_tick` strobes, and every strobe moves the serial clock by one edge. On a rising serial-clock edge the engine samples the input lanes. On a falling edge it shifts the next bit group onto the output lanes. Data goes out and comes in most significant bit first. Each serial clock carries 1, 2 or 4 bits in each direction.

Software programs the lane mode, the byte count, the send and receive enables and the continue bit, then raises the enable. The engine checks that queue space and data are available one byte at a time. If the transmit queue is empty or the receive queue is full, it waits with the serial clock held low. When the last byte has moved it sets a sticky done flag. A soft reset aborts the transaction at any point. An illegal lane code at start time is refused and reported through a sticky configuration-error flag.

Top module: `multi_lane_shift_engine`

## Requirements
- R1: `ctl_mode` code 0 selects 1 lane (`dq_out[0]`), code 1 selects 2 lanes (`dq_out[1:0]`) and code 2 selects 4 lanes (`dq_out[3:0]`). The highest-numbered active lane carries the more significant bit, bytes leave MSB-first, and unused output lanes stay 0.
- R2: Input lanes are sampled on each rising `sclk` edge, with the same lane mapping and bit order as R1. Each assembled byte is presented on `rxq_data` together with a one-cycle `rxq_push`.
- R3: A transaction moves exactly `xfer_len` bytes and then sets `all_done`. A length of 0 sets `all_done` without any `sclk` edge or queue access.
- R4: With `ctl_send_en` low, no byte is popped from the transmit queue and all output lanes stay 0.
- R5: With `ctl_recv_en` low, no byte is pushed to the receive queue.
- R6: A transaction starts only on a rising edge of `ctl_enable`. Holding enable high after completion starts nothing new.
- R7: Before each byte the engine waits, with `sclk` held low, while the transmit queue is empty (send enabled) or the receive queue is full (receive enabled).
- R8: `ctl_soft_rst` aborts any transaction. The next cycle shows `cs_n` high, `sclk` low and both status flags cleared.
- R9: At the end of a transaction `cs_n` stays low if `ctl_continue` was set at start, and returns high otherwise.
- R10: `all_done` stays set until a `clr_done` pulse clears it.
- R11: A start with a `ctl_mode` code from 3 to 7 sets the sticky `cfg_error` flag, cleared by `clr_err`, and produces no `sclk` edge, no `cs_n` assertion and no done.
- R12: `cs_n` is low whenever `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Rising edge starts a transaction |
| ctl_soft_rst | input | 1 | Abort and return to idle |
| ctl_continue | input | 1 | Keep chip-select low after completion |
| ctl_send_en | input | 1 | Send transmit-queue data (else zeros) |
| ctl_recv_en | input | 1 | Push received bytes to the receive queue |
| ctl_mode | input | 3 | Lane code: 0 one lane, 1 two lanes, 2 four lanes |
| xfer_len | input | LEN_W | Transaction length in bytes |
| clr_done | input | 1 | Clear `all_done` |
| clr_err | input | 1 | Clear `cfg_error` |
| sclk_tick | input | 1 | Serial clock edge strobe |
| txq_data | input | BYTE_W | Head byte of the transmit queue |
| txq_valid | input | 1 | Transmit queue not empty |
| txq_pop | output | 1 | Consume the head transmit byte |
| rxq_data | output | BYTE_W | Received byte |
| rxq_push | output | 1 | Write `rxq_data` into the receive queue |
| rxq_full | input | 1 | Receive queue full |
| sclk | output | 1 | Serial clock (idles low) |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Output data lanes |
| dq_in | input | 4 | Input data lanes |
| all_done | output | 1 | Sticky transaction-complete flag |
| cfg_error | output | 1 | Sticky illegal-mode flag |

## Verification
The bench sweeps every lane mode against several lengths and every useful combination of send and receive enables. It decodes the output lanes independently at each rising serial-clock edge and loops the inverted lanes back as input. A design that swapped lanes, shifted by the wrong group width or miscounted bytes would therefore return wrong bytes or the wrong byte count. Zero length, an illegal mode code, transmit-empty and receive-full stalls, an abort part-way through a byte, and enable held high after completion each get their own scenario. A design that handled any of these wrongly would keep clocking, would start a second transaction, or would leave chip-select or the flags in the wrong state.

// File: rtl/mlse_pkg.sv
package mlse_pkg;
  typedef enum logic [2:0] {
    LANE_X1 = 3'd0,
    LANE_X2 = 3'd1,
    LANE_X4 = 3'd2
  } lane_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_LEAD,
    S_TRAIL
  } seq_state_e;

  function automatic logic mode_legal(input logic [2:0] code);
    return code <= 3'd2;
  endfunction
endpackage

// File: rtl/lane_shift_path.sv
module lane_shift_path
  import mlse_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              advance,
  input  logic              capture,
  input  lane_mode_e        mode,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_byte;
    end else if (advance) begin
      unique case (mode)
        LANE_X2: tx_sr <= tx_sr << 2;
        LANE_X4: tx_sr <= tx_sr << 4;
        default: tx_sr <= tx_sr << 1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr <= '0;
    end else if (capture) begin
      unique case (mode)
        LANE_X2: rx_sr <= {rx_sr[BYTE_W-3:0], dq_in[1:0]};
        LANE_X4: rx_sr <= {rx_sr[BYTE_W-5:0], dq_in[3:0]};
        default: rx_sr <= {rx_sr[BYTE_W-2:0], dq_in[0]};
      endcase
    end
  end

  always_comb begin
    dq_out = '0;
    unique case (mode)
      LANE_X2: dq_out[1:0] = tx_sr[BYTE_W-1 -: 2];
      LANE_X4: dq_out[3:0] = tx_sr[BYTE_W-1 -: 4];
      default: dq_out[0]   = tx_sr[BYTE_W-1];
    endcase
  end

  assign rx_byte = rx_sr;
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import mlse_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             enable,
  input  logic             cont,
  input  logic             send_en,
  input  logic             recv_en,
  input  logic [2:0]       mode_code,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  input  logic             tx_valid,
  input  logic             rx_full,
  output logic             tx_pop,
  output logic             rx_push,
  output logic             load,
  output logic             advance,
  output logic             capture,
  output logic             sclk,
  output logic             cs_n,
  output logic             done_set,
  output logic             err_set,
  output lane_mode_e       mode_q,
  output logic             send_q,
  output logic             recv_q
);
  localparam int GW = $clog2(BYTE_W);
  localparam logic [GW-1:0] LAST_X1 = GW'(BYTE_W - 1);
  localparam logic [GW-1:0] LAST_X2 = GW'(BYTE_W / 2 - 1);
  localparam logic [GW-1:0] LAST_X4 = GW'(BYTE_W / 4 - 1);

  seq_state_e       st;
  logic             en_q;
  logic             cont_q;
  logic [LEN_W-1:0] left;
  logic [GW-1:0]    grp;
  logic [GW-1:0]    grp_last;
  logic             start;
  logic             ready;

  assign start = enable && !en_q;
  assign ready = (!send_q || tx_valid) && (!recv_q || !rx_full);

  always_comb begin
    unique case (mode_q)
      LANE_X2: grp_last = LAST_X2;
      LANE_X4: grp_last = LAST_X4;
      default: grp_last = LAST_X1;
    endcase
  end

  assign load    = (st == S_FETCH) && ready;
  assign capture = (st == S_LEAD) && tick;
  assign advance = (st == S_TRAIL) && tick;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enable;
  end

  always_ff @(posedge clk) begin
    tx_pop   <= 1'b0;
    rx_push  <= 1'b0;
    done_set <= 1'b0;
    err_set  <= 1'b0;
    if (rst || soft_rst) begin
      st     <= S_IDLE;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      left   <= '0;
      grp    <= '0;
      mode_q <= LANE_X1;
      send_q <= 1'b0;
      recv_q <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            if (!mode_legal(mode_code)) begin
              err_set <= 1'b1;
            end else begin
              mode_q <= lane_mode_e'(mode_code);
              send_q <= send_en;
              recv_q <= recv_en;
              cont_q <= cont;
              if (len == '0) begin
                done_set <= 1'b1;
              end else begin
                left <= len;
                cs_n <= 1'b0;
                st   <= S_FETCH;
              end
            end
          end
        end
        S_FETCH: begin
          if (ready) begin
            tx_pop <= send_q;
            grp    <= '0;
            st     <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (tick) begin
            sclk <= 1'b1;
            st   <= S_TRAIL;
          end
        end
        default: begin
          if (tick) begin
            sclk <= 1'b0;
            grp  <= grp + 1'b1;
            if (grp == grp_last) begin
              rx_push <= recv_q;
              left    <= left - 1'b1;
              if (left == LEN_W'(1)) begin
                done_set <= 1'b1;
                cs_n     <= !cont_q;
                st       <= S_IDLE;
              end else begin
                st <= S_FETCH;
              end
            end else begin
              st <= S_LEAD;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clear_all) flags[i] <= 1'b0;
      else if (set[i])      flags[i] <= 1'b1;
      else if (clr[i])      flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/multi_lane_shift_engine.sv
module multi_lane_shift_engine
  import mlse_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic              ctl_soft_rst,
  input  logic              ctl_continue,
  input  logic              ctl_send_en,
  input  logic              ctl_recv_en,
  input  logic [2:0]        ctl_mode,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              clr_done,
  input  logic              clr_err,
  input  logic              sclk_tick,
  input  logic [BYTE_W-1:0] txq_data,
  input  logic              txq_valid,
  output logic              txq_pop,
  output logic [BYTE_W-1:0] rxq_data,
  output logic              rxq_push,
  input  logic              rxq_full,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        dq_out,
  input  logic [3:0]        dq_in,
  output logic              all_done,
  output logic              cfg_error
);
  lane_mode_e        mode_q;
  logic              send_q;
  logic              recv_q;
  logic              load;
  logic              advance;
  logic              capture;
  logic              done_set;
  logic              err_set;
  logic [BYTE_W-1:0] load_byte;
  logic [1:0]        flag_q;

  assign load_byte = send_q ? txq_data : '0;

  xfer_sequencer #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .soft_rst(ctl_soft_rst), .enable(ctl_enable),
    .cont(ctl_continue), .send_en(ctl_send_en), .recv_en(ctl_recv_en),
    .mode_code(ctl_mode), .len(xfer_len), .tick(sclk_tick),
    .tx_valid(txq_valid), .rx_full(rxq_full), .tx_pop(txq_pop),
    .rx_push(rxq_push), .load(load), .advance(advance), .capture(capture),
    .sclk(sclk), .cs_n(cs_n), .done_set(done_set), .err_set(err_set),
    .mode_q(mode_q), .send_q(send_q), .recv_q(recv_q)
  );

  lane_shift_path #(.BYTE_W(BYTE_W)) u_path (
    .clk(clk), .rst(rst), .clear(ctl_soft_rst), .load(load),
    .load_byte(load_byte), .advance(advance), .capture(capture),
    .mode(mode_q), .dq_in(dq_in), .dq_out(dq_out), .rx_byte(rxq_data)
  );

  sticky_flags #(.N(2)) u_flags (
    .clk(clk), .rst(rst), .clear_all(ctl_soft_rst),
    .set({err_set, done_set}), .clr({clr_err, clr_done}), .flags(flag_q)
  );

  assign all_done  = flag_q[0];
  assign cfg_error = flag_q[1];
endmodule

// File: rtl/shift_engine_checker.sv
module shift_engine_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctl_soft_rst,
  input logic       clr_done,
  input logic       clr_err,
  input logic       txq_valid,
  input logic       txq_pop,
  input logic       rxq_push,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] dq_out,
  input logic       all_done,
  input logic       cfg_error,
  input logic       send_q,
  input logic       recv_q
);
  p_sclk_under_cs_r12: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  p_pop_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    txq_pop |-> $past(txq_valid));

  p_pop_single_r3: assert property (@(posedge clk) disable iff (rst)
    txq_pop |=> !txq_pop);

  p_push_single_r2: assert property (@(posedge clk) disable iff (rst)
    rxq_push |=> !rxq_push);

  p_no_send_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !send_q |-> (dq_out == 4'd0 && !txq_pop));

  p_no_recv_push_r5: assert property (@(posedge clk) disable iff (rst)
    !recv_q |-> !rxq_push);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (all_done && !clr_done && !ctl_soft_rst) |=> all_done);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_error && !clr_err && !ctl_soft_rst) |=> cfg_error);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_soft_rst |=> (cs_n && !sclk && !all_done && !cfg_error));
endmodule

bind multi_lane_shift_engine shift_engine_checker u_chk (.*);

// File: tb/multi_lane_shift_engine_bench.sv
module multi_lane_shift_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_enable = 1'b0, ctl_soft_rst = 1'b0, ctl_continue = 1'b0;
  logic       ctl_send_en = 1'b0, ctl_recv_en = 1'b0;
  logic [2:0] ctl_mode = 3'd0;
  logic [15:0] xfer_len = 16'd0;
  logic       clr_done = 1'b0, clr_err = 1'b0;
  logic       sclk_tick = 1'b0;
  logic [7:0] txq_data;
  logic       txq_valid, txq_pop, rxq_push, rxq_full;
  logic [7:0] rxq_data;
  logic       sclk, cs_n, all_done, cfg_error;
  logic [3:0] dq_out, dq_in;

  int checks = 0, errors = 0;
  logic [7:0] tq [0:15];
  logic [7:0] rb [0:15];
  logic [7:0] mb [0:15];
  int tx_n = 0, txi = 0, rxi = 0, mcnt = 0, mbits = 0, rise_cnt = 0;
  int tx_gate = -1, rx_block = -1, cur_lanes = 1, tick_div = 1, tick_cnt = 0;
  int cs_bad = 0, lane_bad = 0;
  logic [15:0] mon_sr = '0;
  logic sclk_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign txq_valid = (txi < tx_n) && (txi != tx_gate);
  assign txq_data  = (txi < 16) ? tq[txi] : 8'h00;
  assign rxq_full  = (rx_block >= 0) && (rxi >= rx_block);
  assign dq_in     = ~dq_out;

  multi_lane_shift_engine u_multi_lane_shift_engine (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_soft_rst(ctl_soft_rst),
    .ctl_continue(ctl_continue), .ctl_send_en(ctl_send_en),
    .ctl_recv_en(ctl_recv_en), .ctl_mode(ctl_mode), .xfer_len(xfer_len),
    .clr_done(clr_done), .clr_err(clr_err), .sclk_tick(sclk_tick),
    .txq_data(txq_data), .txq_valid(txq_valid), .txq_pop(txq_pop),
    .rxq_data(rxq_data), .rxq_push(rxq_push), .rxq_full(rxq_full),
    .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_in(dq_in),
    .all_done(all_done), .cfg_error(cfg_error)
  );

  // strobe generator and port monitor, both away from the active edge
  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    if (tick_cnt >= tick_div) begin sclk_tick = 1'b1; tick_cnt = 0; end
    else sclk_tick = 1'b0;
  end

  always @(negedge clk) begin
    if (rxq_push) begin
      if (rxi < 16) rb[rxi] = rxq_data;
      rxi = rxi + 1;
    end
    if (txq_pop) txi = txi + 1;
    if (sclk && !sclk_prev) begin
      rise_cnt = rise_cnt + 1;
      if (cs_n) cs_bad = cs_bad + 1;
      if ((dq_out & ~4'((1 << cur_lanes) - 1)) != 4'd0) lane_bad = lane_bad + 1;
      mon_sr = (mon_sr << cur_lanes) | 16'(dq_out & 4'((1 << cur_lanes) - 1));
      mbits = mbits + cur_lanes;
      if (mbits >= 8) begin
        if (mcnt < 16) mb[mcnt] = mon_sr[7:0];
        mcnt = mcnt + 1;
        mbits = 0;
      end
    end
    sclk_prev = sclk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int m, input int n, input bit snd, input bit rcv,
                      input bit cnt);
    @(negedge clk);
    for (int k = 0; k < 16; k++) tq[k] = 8'((k * 37 + m * 11 + n * 5) ^ 8'h5A);
    tx_n = n; txi = 0; rxi = 0; mcnt = 0; mbits = 0; rise_cnt = 0;
    cs_bad = 0; lane_bad = 0;
    cur_lanes = (m == 1) ? 2 : (m == 2) ? 4 : 1;
    ctl_mode = 3'(m); xfer_len = 16'(n); ctl_send_en = snd;
    ctl_recv_en = rcv; ctl_continue = cnt;
    ctl_enable = 1'b1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (all_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic close_xfer();
    @(negedge clk);
    ctl_enable = 1'b0; clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk(all_done == 1'b0, "R10", "done cleared", all_done, 0);
  endtask

  task automatic run_xfer(input int m, input int n, input bit snd, input bit rcv,
                          input bit cnt);
    bit ok;
    int bad_rx = 0, bad_mon = 0;
    prep(m, n, snd, rcv, cnt);
    wait_done(ok);
    @(negedge clk);
    chk(ok, "R3", "done reached", ok, 1);
    chk(rxi == (rcv ? n : 0), rcv ? "R2" : "R5", "push count", rxi, rcv ? n : 0);
    chk(txi == (snd ? n : 0), snd ? "R3" : "R4", "pop count", txi, snd ? n : 0);
    chk(mcnt == n, "R3", "bytes on lanes", mcnt, n);
    for (int k = 0; k < n && k < 16; k++) begin
      if (rcv && rb[k] != ~(snd ? tq[k] : 8'h00)) bad_rx = bad_rx + 1;
      if (mb[k] != (snd ? tq[k] : 8'h00)) bad_mon = bad_mon + 1;
    end
    chk(bad_rx == 0, "R2", "received byte values", bad_rx, 0);
    chk(bad_mon == 0, snd ? "R1" : "R4", "lane byte values", bad_mon, 0);
    chk(lane_bad == 0, "R1", "unused lanes idle", lane_bad, 0);
    chk(cs_bad == 0, "R12", "cs low while clocking", cs_bad, 0);
    chk(cs_n == !cnt, "R9", "cs after end", cs_n, !cnt);
    chk(sclk == 1'b0, "R7", "sclk idles low", sclk, 0);
  endtask

  initial begin
    bit ok;
    int r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R8", "reset idle pins", {cs_n, sclk}, 2);
    chk(all_done == 0 && cfg_error == 0, "R10", "reset flags", {all_done, cfg_error}, 0);
    chk(txq_pop == 0 && rxq_push == 0 && dq_out == 0, "R4", "reset outputs", dq_out, 0);

    // sweep: lane mode x length x direction, two strobe rates
    for (int m = 0; m < 3; m++)
      for (int li = 0; li < 3; li++)
        for (int d = 0; d < 3; d++) begin
          tick_div = ((m + li + d) % 2 == 0) ? 1 : 3;
          run_xfer(m, (li == 0) ? 1 : (li == 1) ? 3 : 6, d != 2, d != 1, 1'b0);
          close_xfer();
        end
    tick_div = 1;

    // continue keeps chip select low; held enable does not restart (R6)
    run_xfer(2, 2, 1, 1, 1);
    r0 = rise_cnt;
    repeat (30) @(negedge clk);
    chk(rise_cnt == r0 && txi == 2, "R6", "no restart on held enable", rise_cnt, r0);
    chk(cs_n == 1'b0, "R9", "cs held by continue", cs_n, 0);
    close_xfer();
    run_xfer(1, 1, 1, 1, 0);
    close_xfer();

    // zero length
    prep(0, 0, 1, 1, 0);
    @(negedge clk); @(negedge clk);
    chk(all_done == 1'b1, "R3", "zero length done", all_done, 1);
    chk(rise_cnt == 0 && txi == 0 && cs_n == 1'b1, "R3", "zero length idle", rise_cnt, 0);
    close_xfer();

    // illegal lane code
    for (int bm = 3; bm < 8; bm++) begin
      prep(bm, 2, 1, 1, 0);
      repeat (6) @(negedge clk);
      chk(cfg_error == 1'b1, "R11", "illegal code flagged", cfg_error, 1);
      chk(cs_n == 1'b1 && rise_cnt == 0 && !all_done, "R11", "illegal code no xfer", rise_cnt, 0);
      ctl_enable = 1'b0; clr_err = 1'b1;
      @(negedge clk); clr_err = 1'b0;
      @(negedge clk);
      chk(cfg_error == 1'b0, "R11", "error cleared", cfg_error, 1'b0);
    end

    // transmit-empty stall
    tx_gate = 1;
    prep(0, 3, 1, 1, 0);
    repeat (60) @(negedge clk);
    chk(rise_cnt == 8 && sclk == 1'b0 && cs_n == 1'b0, "R7", "tx empty stall", rise_cnt, 8);
    chk(all_done == 1'b0, "R7", "not done while stalled", all_done, 0);
    tx_gate = -1;
    wait_done(ok);
    @(negedge clk);
    chk(ok && rxi == 3, "R7", "resumes after tx stall", rxi, 3);
    close_xfer();

    // receive-full stall
    rx_block = 2;
    prep(1, 4, 1, 1, 0);
    repeat (60) @(negedge clk);
    chk(rise_cnt == 8 && sclk == 1'b0 && txi == 2, "R7", "rx full stall", rise_cnt, 8);
    rx_block = -1;
    wait_done(ok);
    @(negedge clk);
    chk(ok && rxi == 4 && rb[3] == ~tq[3], "R7", "resumes after rx stall", rxi, 4);
    close_xfer();

    // abort mid byte
    prep(2, 4, 1, 1, 1);
    for (int c = 0; c < 200 && rise_cnt < 3; c++) @(negedge clk);
    ctl_soft_rst = 1'b1;
    @(negedge clk);
    ctl_soft_rst = 1'b0;
    chk(cs_n == 1'b1 && sclk == 1'b0, "R8", "abort idle pins", {cs_n, sclk}, 2);
    r0 = rise_cnt;
    repeat (30) @(negedge clk);
    chk(rise_cnt == r0 && all_done == 1'b0, "R8", "abort stops clocking", rise_cnt, r0);
    ctl_enable = 1'b0;
    @(negedge clk);
    run_xfer(0, 2, 1, 1, 0);
    close_xfer();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule